// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Front End

This block is the device side of a 128-word by 16-bit serial EEPROM. A host drives a select line, a serial clock and a serial data line. The block oversamples these with its own system clock and acts on each rising serial-clock edge seen while select is high. It collects an instruction made of a start bit, a two-bit opcode and an eight-bit address field. It then decodes the seven commands and keeps the write-enable latch. It answers reads from an internal word array, which it streams out with automatic address advance.

Programming commands (single-word write, fill-all, single-word erase, erase-all) are passed to a separate programming sequencer. The request goes out when select falls, and only if the instruction was complete and the write-enable latch is set. The sequencer reports progress on a busy input and stores results through a word write port. While select is high again, the block shows the ready/busy state on the serial output until the next start bit.

The serial output has its own enable, which stands in for a three-state pin. Both the output and its enable are combinational from registered state and the select input.

Top module: `ser_eeprom_front`

## Requirements
- R1: After reset the output enable and the programming request are low, the write-enable latch is clear and every array word reads as all ones.
- R2: While select is high, leading zeros are ignored. The first one is the start bit, and it is followed by two opcode bits and eight address-field bits, each taken on a rising serial-clock edge, most significant bit first.
- R3: Opcode 10 is a read of the word at the low seven field bits. The bit above them is ignored. On the edge that takes the last field bit the output is enabled and drives a zero. Each later rising edge presents the next data bit, most significant bit first.
- R4: After the last bit of a word, the next rising edge presents the top bit of the word at the next address, with no gap. The address wraps from 127 to 0, and streaming goes on until select falls.
- R5: With opcode 00, field bits [7:6] = 11 set the write-enable latch and 00 clear it. Neither affects reads.
- R6: Opcode 01 (single write) and opcode 00 with field bits [7:6] = 01 (fill-all) take data bits after the field, and the last 16 received form the word. When select falls after at least 16 data bits, a one-cycle request is raised with command code 0 (write) or 1 (fill-all), the address and the word.
- R7: Opcode 11 (single erase) and opcode 00 with field bits [7:6] = 10 (erase-all) raise a request with code 2 or 3 when select falls.
- R8: Programming commands raise no request while the write-enable latch is clear.
- R9: The output enable is low whenever select is low. Select falling aborts a partial instruction, and a write with fewer than 16 data bits raises no request.
- R10: After a request, while select is high and no start bit has arrived, the output is enabled and shows the inverse of the busy input. A start bit ends this.
- R11: The output does not change unless a rising serial-clock edge is seen, so the host may pause the clock at any time.
- R12: A word written through the array write port is returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| csel | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| prog_req | output | 1 | One-cycle programming request |
| prog_cmd | output | 2 | Command code: 0 write, 1 fill-all, 2 erase, 3 erase-all |
| prog_addr | output | 7 | Target word address |
| prog_data | output | 16 | Word to program |
| prog_busy | input | 1 | Sequencer busy flag |
| arr_we | input | 1 | Array word write strobe from the sequencer |
| arr_waddr | input | 7 | Array write address |
| arr_wdata | input | 16 | Array write data |

## Verification
The properties assume that the serial lines are synchronous to the system clock and that each level of the serial clock and select lasts at least one full system-clock period. Under that assumption every serial edge is seen exactly once and the hold rule on the output can be stated from one sample to the next. The stimulus holds every serial-clock phase and every select change for two system clocks, driven just after the active edge. It also waits for the sequencer to drop busy before it sends another instruction.

// File: rtl/ser_eeprom_front.sv
module ser_eeprom_front #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csel,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              prog_req,
  output logic [1:0]        prog_cmd,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  input  logic              prog_busy,
  input  logic              arr_we,
  input  logic [ADDR_W-1:0] arr_waddr,
  input  logic [DATA_W-1:0] arr_wdata
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int FLD_W = ADDR_W + 1;
  localparam int INS_W = FLD_W + 2;
  localparam int CNT_W = $clog2(INS_W + DATA_W + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] INS_LAST = CNT_W'(INS_W - 1);
  localparam logic [CNT_W-1:0] DAT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  localparam logic [1:0] OP_GRP = 2'b00, OP_WR = 2'b01, OP_RD = 2'b10, OP_ER = 2'b11;
  localparam logic [1:0] SUB_WDS = 2'b00, SUB_FILL = 2'b01, SUB_CLR = 2'b10, SUB_WEN = 2'b11;
  localparam logic [1:0] PC_WRITE = 2'd0, PC_FILL = 2'd1, PC_ERASE = 2'd2, PC_CLR = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_HOLD} st_t;

  st_t               st;
  logic              sck_q, csel_q;
  logic [CNT_W-1:0]  cnt;
  logic [FLD_W:0]    sr;
  logic [DATA_W-1:0] dsr, osr;
  logic [ADDR_W-1:0] ptr, pend_addr;
  logic [BIT_W-1:0]  obit;
  logic [1:0]        pend_cmd;
  logic              pend_v, wen_q, stat_q, sdo_q;
  logic [DATA_W-1:0] mem [WORDS];

  logic              rise, cs_fall, rd_mode;
  logic [INS_W-1:0]  word_in;
  logic [1:0]        op, sub;
  logic [ADDR_W-1:0] addr;

  assign rise    = csel & sck & ~sck_q;
  assign cs_fall = csel_q & ~csel;
  assign word_in = {sr, sdi};
  assign op      = word_in[INS_W-1 -: 2];
  assign sub     = word_in[FLD_W-1 -: 2];
  assign addr    = word_in[ADDR_W-1:0];
  assign rd_mode = (st == S_READ);
  assign sdo_oe  = csel & (rd_mode | (st == S_IDLE & stat_q));
  assign sdo     = rd_mode ? sdo_q : ~prog_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sck_q     <= 1'b0;
      csel_q    <= 1'b0;
      cnt       <= '0;
      sr        <= '0;
      dsr       <= '0;
      osr       <= '0;
      ptr       <= '0;
      obit      <= '0;
      pend_v    <= 1'b0;
      pend_cmd  <= PC_WRITE;
      pend_addr <= '0;
      wen_q     <= 1'b0;
      stat_q    <= 1'b0;
      sdo_q     <= 1'b0;
      prog_req  <= 1'b0;
      prog_cmd  <= PC_WRITE;
      prog_addr <= '0;
      prog_data <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      sck_q    <= sck;
      csel_q   <= csel;
      prog_req <= 1'b0;
      if (arr_we) mem[arr_waddr] <= arr_wdata;
      if (!csel) begin
        st     <= S_IDLE;
        cnt    <= '0;
        pend_v <= 1'b0;
        if (cs_fall && pend_v && wen_q) begin
          prog_req  <= 1'b1;
          prog_cmd  <= pend_cmd;
          prog_addr <= pend_addr;
          prog_data <= dsr;
          stat_q    <= 1'b1;
        end
      end else if (rise) begin
        unique case (st)
          S_IDLE: if (sdi) begin
            st     <= S_CMD;
            cnt    <= '0;
            stat_q <= 1'b0;
          end
          S_CMD: if (cnt == INS_LAST) begin
            cnt       <= '0;
            pend_addr <= addr;
            unique case (op)
              OP_RD: begin
                st    <= S_READ;
                osr   <= mem[addr];
                ptr   <= addr + 1'b1;
                obit  <= '0;
                sdo_q <= 1'b0;
              end
              OP_WR: begin
                st       <= S_DATA;
                pend_cmd <= PC_WRITE;
              end
              OP_ER: begin
                st       <= S_HOLD;
                pend_cmd <= PC_ERASE;
                pend_v   <= 1'b1;
              end
              OP_GRP: unique case (sub)
                SUB_WEN: begin wen_q <= 1'b1; st <= S_HOLD; end
                SUB_WDS: begin wen_q <= 1'b0; st <= S_HOLD; end
                SUB_FILL: begin st <= S_DATA; pend_cmd <= PC_FILL; end
                SUB_CLR: begin st <= S_HOLD; pend_cmd <= PC_CLR; pend_v <= 1'b1; end
              endcase
            endcase
          end else begin
            sr  <= word_in[FLD_W:0];
            cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            dsr <= {dsr[DATA_W-2:0], sdi};
            if (cnt != DAT_FULL) cnt <= cnt + 1'b1;
            if (cnt == DAT_LAST) pend_v <= 1'b1;
          end
          S_READ: begin
            sdo_q <= osr[DATA_W-1];
            if (obit == BIT_LAST) begin
              osr  <= mem[ptr];
              ptr  <= ptr + 1'b1;
              obit <= '0;
            end else begin
              osr  <= {osr[DATA_W-2:0], 1'b0};
              obit <= obit + 1'b1;
            end
          end
          S_HOLD: ;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_eeprom_front_chk.sv
module ser_eeprom_front_chk (
  input logic clk,
  input logic rst_n,
  input logic csel,
  input logic sck,
  input logic sdo,
  input logic sdo_oe,
  input logic prog_req,
  input logic rd_mode,
  input logic wen
);
  p_oe_needs_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !csel |-> !sdo_oe);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  p_req_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(wen));

  p_leading_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_mode) |-> !sdo);

  p_hold_without_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && $past(rd_mode) && !($past(sck) && !$past(sck, 2) && $past(csel)))
      |-> $stable(sdo));
endmodule

bind ser_eeprom_front ser_eeprom_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csel(csel), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe),
  .prog_req(prog_req), .rd_mode(rd_mode), .wen(wen_q)
);

// File: tb/ser_eeprom_front_bench.sv
`timescale 1ns/100ps
module ser_eeprom_front_bench;
  localparam int AW = 7, DW = 16, NW = 128;
  localparam int M_IDLE = 0, M_CMD = 1, M_DATA = 2, M_READ = 3, M_HOLD = 4;

  logic clk = 1'b0, rst_n = 1'b0, csel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic prog_busy = 1'b0, arr_we = 1'b0;
  logic [AW-1:0] arr_waddr = '0;
  logic [DW-1:0] arr_wdata = '0;
  logic sdo, sdo_oe, prog_req;
  logic [1:0] prog_cmd;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;

  int vecs = 0, miss = 0, nreq = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  ser_eeprom_front u_ser_eeprom_front (
    .clk(clk), .rst_n(rst_n), .csel(csel), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .prog_req(prog_req), .prog_cmd(prog_cmd), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_busy(prog_busy), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  // programming sequencer stand-in
  int sq_left = 0, sq_idx = 0;
  logic [1:0] sq_cmd = 2'd0;
  logic [AW-1:0] sq_addr = '0;
  logic [DW-1:0] sq_data = '0;
  always @(posedge clk) begin
    arr_we <= 1'b0;
    if (prog_req) begin
      prog_busy <= 1'b1; sq_left <= 20; sq_idx <= 0;
      sq_cmd <= prog_cmd; sq_addr <= prog_addr; sq_data <= prog_data;
    end else if (prog_busy) begin
      if (sq_left > 0) sq_left <= sq_left - 1;
      else if (sq_cmd == 2'd0 || sq_cmd == 2'd2) begin
        arr_we <= 1'b1; arr_waddr <= sq_addr;
        arr_wdata <= (sq_cmd == 2'd0) ? sq_data : '1;
        prog_busy <= 1'b0;
      end else begin
        arr_we <= 1'b1; arr_waddr <= AW'(sq_idx);
        arr_wdata <= (sq_cmd == 2'd1) ? sq_data : '1;
        sq_idx <= sq_idx + 1;
        if (sq_idx == NW - 1) prog_busy <= 1'b0;
      end
    end
  end

  // behavioural reference model
  int mm = M_IDLE, dcount = 0, mptr = 0, e_cmd = 0, e_addr = 0;
  bit inq[$], dq[$], outq[$];
  bit m_wen = 0, m_pend = 0, m_stat = 0, m_do = 0, m_sck = 0, m_cs = 0, exp_req = 0;
  int m_pcmd = 0, m_paddr = 0;
  logic [DW-1:0] e_data = '0;
  logic [DW-1:0] mmem [NW];

  always @(posedge clk) begin
    if (!rst_n) begin
      mm = M_IDLE; m_wen = 0; m_pend = 0; m_stat = 0; m_do = 0; exp_req = 0;
      inq.delete(); dq.delete(); outq.delete();
      for (int i = 0; i < NW; i++) mmem[i] = '1;
      m_sck = sck; m_cs = csel;
    end else begin
      exp_req = 0;
      if (!csel) begin
        if (m_cs) begin
          bit go;
          go = (mm == M_DATA) ? (dcount >= DW) : m_pend;
          if (go && m_wen && (mm == M_DATA || mm == M_HOLD)) begin
            exp_req = 1; e_cmd = m_pcmd; e_addr = m_paddr;
            e_data = '0;
            foreach (dq[k]) e_data = {e_data[DW-2:0], dq[k]};
            m_stat = 1;
          end
        end
        mm = M_IDLE; m_pend = 0; inq.delete();
      end else if (sck && !m_sck) begin
        if (mm == M_IDLE) begin
          if (sdi) begin mm = M_CMD; m_stat = 0; inq.delete(); end
        end else if (mm == M_CMD) begin
          inq.push_back(sdi);
          if (inq.size() == 10) begin
            int op, sb, a;
            op = inq[0] * 2 + inq[1];
            sb = inq[2] * 2 + inq[3];
            a = 0;
            for (int k = 3; k < 10; k++) a = a * 2 + inq[k];
            m_paddr = a;
            if (op == 2) begin
              mm = M_READ; m_do = 0; mptr = a; outq.delete();
            end else if (op == 1 || (op == 0 && sb == 1)) begin
              mm = M_DATA; m_pcmd = (op == 1) ? 0 : 1; dq.delete(); dcount = 0;
            end else if (op == 3 || (op == 0 && sb == 2)) begin
              mm = M_HOLD; m_pcmd = (op == 3) ? 2 : 3; m_pend = 1;
            end else begin
              mm = M_HOLD; m_wen = (sb == 3);
            end
          end
        end else if (mm == M_DATA) begin
          dq.push_back(sdi); dcount++;
          if (dq.size() > DW) void'(dq.pop_front());
        end else if (mm == M_READ) begin
          if (outq.size() == 0) begin
            for (int b = DW - 1; b >= 0; b--) outq.push_back(mmem[mptr][b]);
            mptr = (mptr + 1) % NW;
          end
          m_do = outq.pop_front();
        end
      end
      if (arr_we) mmem[arr_waddr] = arr_wdata;
      m_sck = sck; m_cs = csel;
    end
  end

  task automatic fail(input string what, input int act, input int exp);
    miss++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  always @(negedge clk) if (rst_n) begin
    bit e_oe, e_do;
    vecs++;
    e_oe = csel && (mm == M_READ || (mm == M_IDLE && m_stat));
    e_do = (mm == M_READ) ? m_do : !prog_busy;
    if (prog_req) nreq++;
    if (sdo_oe !== e_oe) fail("sdo_oe", int'(sdo_oe), int'(e_oe));
    else if (e_oe && sdo !== e_do) fail("sdo", int'(sdo), int'(e_do));
    if (prog_req !== exp_req) fail("prog_req", int'(prog_req), int'(exp_req));
    else if (exp_req) begin
      if (prog_cmd !== 2'(e_cmd)) fail("prog_cmd", int'(prog_cmd), e_cmd);
      if ((e_cmd == 0 || e_cmd == 2) && prog_addr !== AW'(e_addr)) fail("prog_addr", int'(prog_addr), e_addr);
      if (e_cmd < 2 && prog_data !== e_data) fail("prog_data", int'(prog_data), int'(e_data));
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    vecs++;
    if (!ok) fail(what, act, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic sk_bit(input logic b);
    sdi = b; sck = 1'b0; tick(2); sck = 1'b1; tick(2);
  endtask
  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask
  task automatic cs_up();
    sck = 1'b0; csel = 1'b1; tick(2);
  endtask
  task automatic cs_down();
    sck = 1'b0; sdi = 1'b0; csel = 1'b0; tick(3);
  endtask
  task automatic instr(input logic [1:0] op, input logic [7:0] fld);
    send({1'b1, op, fld}, 11);
  endtask
  task automatic stream(input int n);
    for (int i = 0; i < n; i++) sk_bit(1'b0);
  endtask
  task automatic wait_idle();
    tick(3);
    while (prog_busy) tick(1);
    tick(3);
  endtask
  task automatic one_cmd(input logic [1:0] op, input logic [7:0] fld);
    cs_up(); instr(op, fld); cs_down();
  endtask

  initial begin
    int n0;
    tick(4);
    tag = "R1";
    chk(sdo_oe === 1'b0, "reset sdo_oe", int'(sdo_oe), 0);
    chk(prog_req === 1'b0, "reset prog_req", int'(prog_req), 0);
    rst_n = 1'b1; tick(2);
    tag = "R1 R3";
    cs_up(); instr(2'b10, 8'h00);
    chk(sdo_oe === 1'b1 && sdo === 1'b0, "dummy bit", int'({sdo_oe, sdo}), 2);
    stream(33); cs_down();
    chk(sdo_oe === 1'b0, "oe after select low R9", int'(sdo_oe), 0);

    tag = "R8"; n0 = nreq;
    cs_up(); instr(2'b01, 8'h05); send(32'h1234, 16); cs_down();
    one_cmd(2'b11, 8'h05);
    chk(nreq == n0, "request count with latch clear", nreq, n0);

    tag = "R5"; one_cmd(2'b00, 8'hC0);
    tag = "R6"; n0 = nreq;
    cs_up(); instr(2'b01, 8'h05); send(32'h9A5C3, 20); cs_down();
    tag = "R10";
    cs_up(); tick(6);
    chk(sdo_oe === 1'b1 && sdo === 1'b0, "busy status", int'({sdo_oe, sdo}), 2);
    tick(40);
    chk(sdo_oe === 1'b1 && sdo === 1'b1, "ready status", int'({sdo_oe, sdo}), 3);
    sk_bit(1'b0);
    sk_bit(1'b1);
    chk(sdo_oe === 1'b0, "status ended by start bit", int'(sdo_oe), 0);
    cs_down();
    chk(nreq == n0 + 1, "one write request R6", nreq, n0 + 1);

    tag = "R3 R12";
    cs_up(); instr(2'b10, 8'h85); stream(34); cs_down();

    tag = "R4"; wait_idle();
    cs_up(); instr(2'b01, 8'h7F); send(32'hBEEF, 16); cs_down(); wait_idle();
    cs_up(); instr(2'b10, 8'h7E); stream(49); cs_down();

    tag = "R7"; one_cmd(2'b11, 8'h05); wait_idle();
    cs_up(); instr(2'b10, 8'h04); stream(34); cs_down();
    tag = "R6";
    cs_up(); instr(2'b00, 8'h40); send(32'h3C3C, 16); cs_down(); wait_idle();
    cs_up(); instr(2'b10, 8'h10); stream(40); cs_down();
    tag = "R7"; one_cmd(2'b00, 8'h80); wait_idle();
    cs_up(); instr(2'b10, 8'h20); stream(20); cs_down();

    tag = "R5"; one_cmd(2'b00, 8'h00); n0 = nreq;
    tag = "R8";
    cs_up(); instr(2'b01, 8'h02); send(32'h5555, 16); cs_down();
    one_cmd(2'b00, 8'h80);
    chk(nreq == n0, "no request after disable", nreq, n0);
    tag = "R5";
    cs_up(); instr(2'b10, 8'h7F); stream(20); cs_down();

    tag = "R9"; one_cmd(2'b00, 8'hC0); n0 = nreq;
    cs_up(); send(32'h6, 3); cs_down();
    cs_up(); instr(2'b01, 8'h03); send(32'h3FF, 10); cs_down();
    chk(nreq == n0, "short write dropped", nreq, n0);
    tag = "R2";
    cs_up(); send(32'h0, 5); instr(2'b10, 8'h7F); stream(18); cs_down();

    tag = "R11";
    cs_up(); instr(2'b10, 8'h7F); stream(5);
    sck = 1'b1; tick(30); sck = 1'b0; tick(30);
    stream(14); cs_down();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule